// File: doc/BRIEF.md
# HDLC Transmit Stop/Restart Controller

This block is the control state machine of one HDLC transmit channel. It decides when the channel looks for a ready transmit descriptor, and how it halts and resumes. The serializer, CRC, bit stuffing and descriptor memory sit outside it. The framer reports the start and end of each frame and supplies a per-bit transmit clock enable. The controller answers with a descriptor poll request, a FIFO flush, an abort-pattern request, the fill pattern to send between frames, a pointer-advance pulse and a sticky graceful-stop event.

Two kinds of stop are supported. An abrupt stop issued during a frame lets the line carry a bounded number of further bits. It then requests the abort pattern and flushes the FIFO, and the channel stays halted without touching the descriptor pointer. A graceful stop lets the current frame finish, advances the pointer past it and raises the event. Transmission then resumes only on a restart command that arrives while the next descriptor is ready.

Top module: `hdlc_tx_ctrl`

## Requirements
- R1: After reset, with the channel disabled, poll_req_o, abort_req_o, fifo_flush_o, ptr_adv_o and gsc_evt_o are 0. Fill is selected (fill_idle_o = 1 when fill_mode_i = 0).
- R2: While the channel is enabled and between frames, poll_req_o pulses on the cycle that carries the POLL_BITS-th (256) asserted bit_en_i since the channel became active or since the last poll.
- R3: tod_i asserted while the channel is enabled and between frames makes poll_req_o high in the same cycle and restarts the poll interval.
- R4: An abrupt stop (stop_i) taken during a frame makes abort_req_o and fifo_flush_o high together for exactly one cycle. That cycle follows the ABORT_BITS-th (64) bit_en_i counted after the stop, or follows frame_end_i if the frame ends earlier.
- R5: Whenever no frame or abort is on the line, fill_flags_o equals fill_mode_i and fill_idle_o equals its inverse (1 = flags, 0 = idles). Both are 0 during a frame.
- R6: After an abrupt stop, neither poll_req_o nor ptr_adv_o rises, whatever tod_i, frame_start_i or frame_end_i do, until a restart is accepted.
- R7: An abrupt stop taken between frames pulses fifo_flush_o for one cycle, on the cycle after the stop, with abort_req_o held at 0.
- R8: A graceful stop (gstop_i) taken during a frame lets the frame finish. ptr_adv_o pulses with frame_end_i, gsc_evt_o is 1 from the next cycle, and no poll follows.
- R9: A graceful stop taken between frames sets gsc_evt_o on the next cycle and stops polling.
- R10: A stopped channel resumes only when restart_i and bd_ready_i are both high in the same cycle. restart_i alone has no effect.
- R11: gsc_evt_o clears only on gsc_clr_i. Stop and graceful-stop commands received while stopped are ignored: no flush and no event.
- R12: During a normal frame, ptr_adv_o is high in the cycle frame_end_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | 1 | Channel enable; low forces the off state |
| stop_i | input | 1 | Abrupt stop command strobe |
| gstop_i | input | 1 | Graceful stop command strobe |
| restart_i | input | 1 | Restart command strobe |
| bd_ready_i | input | 1 | Ready bit of the current descriptor |
| tod_i | input | 1 | Transmit-on-demand: poll now |
| bit_en_i | input | 1 | One line bit is sent this cycle |
| frame_start_i | input | 1 | Framer begins a frame |
| frame_end_i | input | 1 | Framer finishes the current frame |
| fill_mode_i | input | 1 | Fill selection: 1 flags, 0 idles |
| gsc_clr_i | input | 1 | Write-one-to-clear of the graceful-stop event |
| poll_req_o | output | 1 | Descriptor poll request pulse |
| fifo_flush_o | output | 1 | Flush the transmit FIFO |
| abort_req_o | output | 1 | Send the abort pattern 0x7F |
| fill_flags_o | output | 1 | Line sends flags between frames |
| fill_idle_o | output | 1 | Line sends idles between frames |
| ptr_adv_o | output | 1 | Advance the descriptor pointer |
| gsc_evt_o | output | 1 | Sticky graceful-stop-complete event |

## Verification
The hardest case to reach is the abort bound. An abrupt stop has to land inside a frame, and the 64-bit window has to be measured in line bits rather than clock cycles. The bench opens a frame and issues the stop. It then drives bit_en_i at full rate and at half rate, with the frame ending earlier, at the limit or never, and measures the cycle of the abort pulse against the limit. The other hard case is an ignored command while the channel is stopped. It is checked by watching fifo_flush_o and gsc_evt_o stay unchanged, and by seeing no poll appear under tod_i.

// File: rtl/hdlc_tx_ctrl_pkg.sv
package hdlc_tx_ctrl_pkg;
  typedef enum logic [3:0] {
    ST_OFF,
    ST_RUN,         // enabled, between frames, polling
    ST_FRAME,       // frame on the line
    ST_GDRAIN,      // graceful stop pending end of frame
    ST_ABORT_WAIT,  // abrupt stop, bounded bits still allowed
    ST_ABORT_SEND,  // abort pattern + flush
    ST_FLUSH,       // abrupt stop between frames
    ST_STOPPED,
    ST_GSTOP
  } tx_state_e;
endpackage

// File: rtl/hdlc_bit_timer.sv
module hdlc_bit_timer #(
  parameter int LIMIT = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign hit_o = en_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || hit_o)  cnt_q <= '0;
    else if (en_i)            cnt_q <= cnt_q + 1'b1;
  end

  // R2 R4
  hit_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);
endmodule

// File: rtl/hdlc_tx_fsm.sv
module hdlc_tx_fsm
  import hdlc_tx_ctrl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      chan_en_i,
  input  logic      stop_i,
  input  logic      gstop_i,
  input  logic      restart_i,
  input  logic      bd_ready_i,
  input  logic      frame_start_i,
  input  logic      frame_end_i,
  input  logic      abort_hit_i,
  input  logic      gsc_clr_i,
  output tx_state_e state_o,
  output logic      gsc_evt_o
);
  tx_state_e state_q, state_d;
  logic      gsc_q;

  always_comb begin
    state_d = state_q;
    if (!chan_en_i) state_d = ST_OFF;
    else begin
      case (state_q)
        ST_OFF: state_d = ST_RUN;
        ST_RUN: begin
          if (stop_i)             state_d = ST_FLUSH;
          else if (gstop_i)       state_d = ST_GSTOP;
          else if (frame_start_i) state_d = ST_FRAME;
        end
        ST_FRAME: begin
          if (stop_i)           state_d = ST_ABORT_WAIT;
          else if (frame_end_i) state_d = gstop_i ? ST_GSTOP : ST_RUN;
          else if (gstop_i)     state_d = ST_GDRAIN;
        end
        ST_GDRAIN: begin
          if (stop_i)           state_d = ST_ABORT_WAIT;
          else if (frame_end_i) state_d = ST_GSTOP;
        end
        ST_ABORT_WAIT: if (abort_hit_i || frame_end_i) state_d = ST_ABORT_SEND;
        ST_ABORT_SEND,
        ST_FLUSH:      state_d = ST_STOPPED;
        ST_STOPPED,
        ST_GSTOP:      if (restart_i && bd_ready_i) state_d = ST_RUN;
        default:       state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      gsc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      // entry into graceful stop wins over a same-cycle clear
      if (state_d == ST_GSTOP && state_q != ST_GSTOP) gsc_q <= 1'b1;
      else if (gsc_clr_i)                             gsc_q <= 1'b0;
    end
  end

  assign state_o   = state_q;
  assign gsc_evt_o = gsc_q;

  // R11
  gsc_clear_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gsc_q) |-> $past(gsc_clr_i));
endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_ctrl_pkg::*;
#(
  parameter int POLL_BITS  = 256,
  parameter int ABORT_BITS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chan_en_i,
  input  logic stop_i,
  input  logic gstop_i,
  input  logic restart_i,
  input  logic bd_ready_i,
  input  logic tod_i,
  input  logic bit_en_i,
  input  logic frame_start_i,
  input  logic frame_end_i,
  input  logic fill_mode_i,
  input  logic gsc_clr_i,
  output logic poll_req_o,
  output logic fifo_flush_o,
  output logic abort_req_o,
  output logic fill_flags_o,
  output logic fill_idle_o,
  output logic ptr_adv_o,
  output logic gsc_evt_o
);
  tx_state_e state;
  logic      in_run, poll_clr, poll_hit, abort_hit, on_line;

  assign in_run   = (state == ST_RUN);
  assign poll_clr = !in_run || tod_i;

  hdlc_bit_timer #(.LIMIT(POLL_BITS)) u_poll_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (poll_clr),
    .en_i  (bit_en_i),
    .hit_o (poll_hit)
  );

  hdlc_bit_timer #(.LIMIT(ABORT_BITS)) u_abort_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state != ST_ABORT_WAIT),
    .en_i  (bit_en_i),
    .hit_o (abort_hit)
  );

  hdlc_tx_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .chan_en_i    (chan_en_i),
    .stop_i       (stop_i),
    .gstop_i      (gstop_i),
    .restart_i    (restart_i),
    .bd_ready_i   (bd_ready_i),
    .frame_start_i(frame_start_i),
    .frame_end_i  (frame_end_i),
    .abort_hit_i  (abort_hit),
    .gsc_clr_i    (gsc_clr_i),
    .state_o      (state),
    .gsc_evt_o    (gsc_evt_o)
  );

  // frame data or abort pattern occupies the line
  assign on_line = (state == ST_FRAME) || (state == ST_GDRAIN) ||
                   (state == ST_ABORT_WAIT) || (state == ST_ABORT_SEND);

  assign poll_req_o   = in_run && (tod_i || poll_hit);
  assign abort_req_o  = (state == ST_ABORT_SEND);
  assign fifo_flush_o = (state == ST_ABORT_SEND) || (state == ST_FLUSH);
  assign ptr_adv_o    = frame_end_i && !stop_i &&
                        ((state == ST_FRAME) || (state == ST_GDRAIN));
  assign fill_flags_o = !on_line && fill_mode_i;
  assign fill_idle_o  = !on_line && !fill_mode_i;

  // R4
  abort_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_req_o |=> !abort_req_o && !poll_req_o);

  // R5
  fill_after_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_req_o |=> (fill_flags_o || fill_idle_o));

  // R6
  no_poll_after_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_flush_o |=> !poll_req_o && !ptr_adv_o);

  // R9
  gsc_no_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gsc_evt_o) |-> !poll_req_o);

  // R11
  gsc_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gsc_evt_o && !gsc_clr_i |=> gsc_evt_o);
endmodule

// File: tb/hdlc_tx_ctrl_tb.sv
module hdlc_tx_ctrl_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni;
  logic chan_en_i, stop_i, gstop_i, restart_i, bd_ready_i, tod_i, bit_en_i;
  logic frame_start_i, frame_end_i, fill_mode_i, gsc_clr_i;
  logic poll_req_o, fifo_flush_o, abort_req_o, fill_flags_o, fill_idle_o;
  logic ptr_adv_o, gsc_evt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  hdlc_tx_ctrl dut_i (.*);

  // abrupt-stop vectors: frame end cycle (0 = never), bit_en rate, fill mode
  localparam int NV = 6;
  localparam int V_END [NV] = '{0, 0, 0, 10, 64, 200};
  localparam int V_RATE[NV] = '{1, 1, 2, 1, 1, 1};
  localparam int V_MODE[NV] = '{0, 1, 1, 0, 1, 0};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    {chan_en_i, stop_i, gstop_i, restart_i, bd_ready_i, tod_i, bit_en_i} = '0;
    {frame_start_i, frame_end_i, fill_mode_i, gsc_clr_i} = '0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int first, second, hits;
    do_reset();
    #1;
    chk("R1 poll", poll_req_o, 0);
    chk("R1 abort", abort_req_o, 0);
    chk("R1 flush", fifo_flush_o, 0);
    chk("R1 ptr", ptr_adv_o, 0);
    chk("R1 gsc", gsc_evt_o, 0);
    chk("R1 fill_idle", fill_idle_o, 1);

    // R2 periodic poll
    chan_en_i = 1; bit_en_i = 1;
    first = 0; second = 0;
    for (int k = 1; k <= 600; k++) begin
      cyc(); #1;
      if (poll_req_o) begin
        if (first == 0) first = k;
        else if (second == 0) second = k;
      end
    end
    chk("R2 first poll", first, 256);
    chk("R2 interval", second - first, 256);

    // R3 transmit on demand
    cyc(); tod_i = 1; #1;
    chk("R3 tod poll", poll_req_o, 1);
    cyc(); tod_i = 0;
    first = 0;
    for (int k = 1; k <= 300; k++) begin
      #1; if (poll_req_o && first == 0) first = k;
      cyc();
    end
    chk("R3 interval restart", first, 256);

    // R12 normal frame, R5 fill during frame
    frame_start_i = 1; cyc(); frame_start_i = 0;
    cyc(); cyc(); #1;
    chk("R5 no fill in frame", fill_idle_o | fill_flags_o, 0);
    cyc(); frame_end_i = 1; #1;
    chk("R12 ptr_adv", ptr_adv_o, 1);
    cyc(); frame_end_i = 0; #1;
    chk("R12 ptr single", ptr_adv_o, 0);
    chk("R5 fill back", fill_idle_o, 1);

    // R7 stop between frames
    cyc(); stop_i = 1; cyc(); stop_i = 0; #1;
    chk("R7 flush", fifo_flush_o, 1);
    chk("R7 no abort", abort_req_o, 0);
    cyc(); #1;
    chk("R7 flush single", fifo_flush_o, 0);

    // R6 stopped: no poll, no pointer move
    hits = 0; tod_i = 1;
    for (int k = 0; k < 300; k++) begin
      frame_end_i = k[0]; frame_start_i = (k == 5);
      #1; hits += int'(poll_req_o) + int'(ptr_adv_o);
      cyc();
    end
    tod_i = 0; frame_end_i = 0; frame_start_i = 0;
    chk("R6 quiet when stopped", hits, 0);
    stop_i = 1; cyc(); stop_i = 0; #1;
    chk("R11 stop ignored", fifo_flush_o, 0);

    // R10 restart needs ready descriptor
    restart_i = 1; bd_ready_i = 0; cyc(); restart_i = 0; tod_i = 1; #1;
    chk("R10 restart w/o ready", poll_req_o, 0);
    tod_i = 0; restart_i = 1; bd_ready_i = 1; cyc();
    restart_i = 0; bd_ready_i = 0; tod_i = 1; #1;
    chk("R10 resumed", poll_req_o, 1);
    tod_i = 0;

    // R8 graceful stop mid-frame
    cyc(); frame_start_i = 1; cyc(); frame_start_i = 0; gstop_i = 1;
    cyc(); gstop_i = 0;
    repeat (5) cyc();
    #1 chk("R8 gsc not yet", gsc_evt_o, 0);
    frame_end_i = 1; #1;
    chk("R8 ptr at end", ptr_adv_o, 1);
    cyc(); frame_end_i = 0; tod_i = 1; #1;
    chk("R8 gsc set", gsc_evt_o, 1);
    chk("R8 no poll", poll_req_o, 0);
    tod_i = 0;

    // R11 ignored commands, clear only by w1c
    cyc(); stop_i = 1; cyc(); stop_i = 0; #1;
    chk("R11 stop ignored in gstop", fifo_flush_o, 0);
    chk("R11 gsc held", gsc_evt_o, 1);
    gsc_clr_i = 1; cyc(); gsc_clr_i = 0; #1;
    chk("R11 gsc cleared", gsc_evt_o, 0);
    gstop_i = 1; cyc(); gstop_i = 0; #1;
    chk("R11 gstop ignored", gsc_evt_o, 0);

    // R9 graceful stop while idle
    restart_i = 1; bd_ready_i = 1; cyc(); restart_i = 0; bd_ready_i = 0;
    gstop_i = 1; cyc(); gstop_i = 0; tod_i = 1; #1;
    chk("R9 gsc idle", gsc_evt_o, 1);
    chk("R9 no poll", poll_req_o, 0);
    tod_i = 0;

    // R4 / R5 abrupt stop vector table
    for (int v = 0; v < NV; v++) begin
      int n, seen, flush_at, ptr_hits, exp_n;
      do_reset();
      fill_mode_i = V_MODE[v][0]; chan_en_i = 1; bit_en_i = 1;
      cyc(); frame_start_i = 1;
      cyc(); frame_start_i = 0; stop_i = 1;
      cyc(); stop_i = 0;
      seen = 0; flush_at = 0; ptr_hits = 0;
      for (n = 1; n <= 200; n++) begin
        bit_en_i    = ((n % V_RATE[v]) == 0);
        frame_end_i = (V_END[v] > 0) && (n == V_END[v]);
        #1;
        ptr_hits += int'(ptr_adv_o);
        if (abort_req_o) begin seen = n; flush_at = int'(fifo_flush_o); break; end
        cyc();
      end
      exp_n = (V_END[v] > 0 && V_END[v] < 64 * V_RATE[v]) ? V_END[v] + 1
                                                         : 64 * V_RATE[v] + 1;
      chk("R4 abort cycle", seen, exp_n);
      chk("R4 flush with abort", flush_at, 1);
      chk("R6 no ptr on abort", ptr_hits, 0);
      cyc(); frame_end_i = 0; bit_en_i = 1; #1;
      chk("R4 abort single", abort_req_o, 0);
      chk("R5 fill flags", fill_flags_o, V_MODE[v]);
      chk("R5 fill idle", fill_idle_o, 1 - V_MODE[v]);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule